// File: doc/BRIEF.md
# Buffered SPI Master Port

This block is a byte-wide serial master that exchanges one byte at a time with an attached device over a three-wire synchronous link (serial clock, data out, data in). Software writes a byte into a single buffer register, and that write starts the transfer. The byte is moved into a hidden shift register and sent most-significant bit first. At the same time a byte is collected from the data-in line. When the exchange finishes, the received byte replaces the written byte in the same buffer register and a sticky completion flag rises. Software must clear that flag with a strobe.

The serial clock comes from one of four sources. Three of them divide the system clock by 4, 16 or 64. The fourth is an external timer pulse: each pulse toggles the serial clock, so two pulses make one full clock period. Three independent configuration bits set the idle level of the clock, whether the first data bit is driven at once or on the first clock edge, and whether the data-in line is sampled in the middle or at the end of each output bit. A write that arrives while a transfer is running is refused and raises a sticky collision flag. Device selection is handled outside this block.

Time is counted in serial half-periods, called ticks, numbered 1 upward from the start of a transfer. With launch offset L (0 or 1, set by the edge-select bit), bit i (0 = MSB) is driven at tick L+2i. It is sampled at tick L+2i+1 in middle mode and at tick L+2i+2 in end mode. The serial clock toggles on ticks 1 to 16. The transfer ends on tick 17 when both the edge-select bit and the end-sample bit are 1, and on tick 16 otherwise.

Top module: `spi_buf_master`

## Requirements
- R1: A pulse on wr_en while busy is low starts a transfer. After that clock edge busy is 1 and rd_data shows the written byte.
- R2: Data is exchanged full-duplex, MSB first. When the transfer ends, rd_data holds the byte sampled from sdi, with the first sampled bit in bit 7.
- R3: done rises on the clock edge that ends a transfer and stays 1 until a done_clr pulse. If the set and the clear fall on the same edge, the set wins.
- R4: cfg_clk_sel 0, 1 and 2 give ticks every 2, 8 and 32 system clocks (divide by 4, 16, 64). Busy therefore lasts 16 or 17 times that spacing.
- R5: cfg_clk_sel 3 makes each tmr_tick pulse that arrives during a transfer one tick. With no pulses, the transfer does not advance.
- R6: While the port is idle, sck equals cfg_cpol. Every transfer toggles sck exactly 16 times and leaves it at the idle level.
- R7: With cfg_cke 0, bit 7 appears on sdo at the start edge and each further bit appears on an even tick. With cfg_cke 1, bit 7 appears on tick 1 and later bits appear on odd ticks.
- R8: With cfg_smp 0, sdi is sampled one tick after each bit is driven. With cfg_smp 1, it is sampled two ticks after.
- R9: A wr_en pulse while busy sets the sticky wcol flag, which is cleared by wcol_clr (set wins). Such a write changes neither the buffer nor the running transfer.
- R10: busy stays high from the start edge until the edge that sets done, then falls.
- R11: After a synchronous reset, sck equals cfg_cpol, sdo, busy, done and wcol are 0, and rd_data is 0. sdo holds its last value while the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_clk_sel | input | 2 | Serial clock source: 0 div4, 1 div16, 2 div64, 3 timer |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cke | input | 1 | 0: first bit driven at start; 1: first bit driven on first edge |
| cfg_smp | input | 1 | 0: sample mid-bit; 1: sample at bit end |
| tmr_tick | input | 1 | External timer pulse, one system clock wide |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte written to the buffer |
| rd_data | output | 8 | Buffer register contents |
| done_clr | input | 1 | Clears the completion flag |
| wcol_clr | input | 1 | Clears the collision flag |
| done | output | 1 | Sticky completion flag |
| wcol | output | 1 | Sticky write-collision flag |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong tick count or divider shows on sck within one half-period, and on the length of busy by the end of the transfer. A sampling-phase or shift error stays hidden inside the shift register until the last tick, and then shows as a wrong byte on rd_data. A launch error shows on sdo at the first bit that moves. The bench drives a changing pseudo-random sdi so that sampling on a neighbouring tick gives a different byte. It compares every output against a behavioural model on every clock.

// File: rtl/spi_buf_pkg.sv
// Package: shared types for the buffered SPI master.
// Assumes nothing beyond standard SystemVerilog.
package spi_buf_pkg;
    typedef enum logic [1:0] {
        SRC_DIV_A = 2'd0,
        SRC_DIV_B = 2'd1,
        SRC_DIV_C = 2'd2,
        SRC_TMR   = 2'd3
    } spi_clk_src_e;
endpackage

// File: rtl/spi_tick_gen.sv
// Half-period tick generator. While run is high it emits one-cycle ticks,
// either from a system-clock divider or from the external timer pulse.
// Assumes sel is stable while run is high; the counter restarts whenever run is low.
module spi_tick_gen
    import spi_buf_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  spi_clk_src_e sel,
    input  logic         tmr_tick,
    output logic         tick
);
    localparam int HALF_MAX = DIV_C / 2;
    localparam int LIMW     = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;
    localparam logic [LIMW-1:0] LIM_A = LIMW'(DIV_A / 2 - 1);
    localparam logic [LIMW-1:0] LIM_B = LIMW'(DIV_B / 2 - 1);
    localparam logic [LIMW-1:0] LIM_C = LIMW'(DIV_C / 2 - 1);

    logic [LIMW-1:0] cnt_q;
    logic [LIMW-1:0] lim;

    // Choose the terminal count for the selected divider.
    always_comb begin
        case (sel)
            SRC_DIV_A: lim = LIM_A;
            SRC_DIV_B: lim = LIM_B;
            default:   lim = LIM_C;
        endcase
    end

    // Raise a tick on terminal count, or pass the timer pulse through.
    always_comb begin
        if (sel == SRC_TMR) tick = run & tmr_tick;
        else                tick = run & (cnt_q == lim);
    end

    // Count system clocks within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      cnt_q <= '0;
        else if (sel != SRC_TMR) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end

    // R4: every divider half-period is at least two clocks long.
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != SRC_TMR && run) |=> !tick);
endmodule

// File: rtl/spi_bit_seq.sv
// Bit sequencer: counts ticks within a transfer and decodes which tick
// toggles sck, drives the next bit, samples sdi, or ends the transfer.
// Assumes cke and smp are stable while a transfer runs.
module spi_bit_seq #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic cke,
    input  logic smp,
    output logic toggle,
    output logic launch,
    output logic sample,
    output logic finish
);
    localparam int NTOG = 2 * W;
    localparam int LAST = 2 * (W - 1);
    localparam int CW   = $clog2(NTOG + 2);

    logic [CW-1:0] n_q;
    logic [CW-1:0] n_nxt;
    int            d_l;
    int            d_s;
    int            end_n;

    // Decode the number of the tick now arriving into per-tick actions.
    always_comb begin
        n_nxt  = n_q + 1'b1;
        d_l    = int'(n_nxt) - int'(cke);
        d_s    = int'(n_nxt) - int'(cke) - 1 - int'(smp);
        end_n  = (cke && smp) ? NTOG + 1 : NTOG;
        toggle = tick && (int'(n_nxt) <= NTOG);
        launch = tick && (d_l >= 0) && (d_l[0] == 1'b0) && (d_l <= LAST);
        sample = tick && (d_s >= 0) && (d_s[0] == 1'b0) && (d_s <= LAST);
        finish = tick && (int'(n_nxt) == end_n);
    end

    // Hold the count of ticks seen since the transfer began.
    always_ff @(posedge clk) begin
        if (!rst_n || start) n_q <= '0;
        else if (tick)       n_q <= n_nxt;
    end

    // R8: middle sampling never shares a tick with a data change.
    a_r8_mid_split: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp && tick) |-> !(launch && sample));
    // R7: no bit is driven on the closing tick.
    a_r7_no_late_launch: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> !launch);
endmodule

// File: rtl/spi_buf_master.sv
// Buffered SPI master top: one buffer register for both directions, a hidden
// shift register, sticky completion and collision flags, and a configurable
// clock source, polarity, launch edge and sample point.
// Assumes configuration inputs change only while busy is low.
module spi_buf_master
    import spi_buf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cfg_clk_sel,
    input  logic         cfg_cpol,
    input  logic         cfg_cke,
    input  logic         cfg_smp,
    input  logic         tmr_tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         done_clr,
    input  logic         wcol_clr,
    output logic         done,
    output logic         wcol,
    output logic         busy,
    output logic         sck,
    output logic         sdo,
    input  logic         sdi
);
    logic [W-1:0] buf_q, sr_q, sr_smp, sr_nxt;
    logic         busy_q, done_q, wcol_q, sck_q, sdo_q;
    logic         start, tick, toggle, launch, sample, finish;

    assign start = wr_en & ~busy_q;

    spi_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy_q),
        .sel(spi_clk_src_e'(cfg_clk_sel)), .tmr_tick(tmr_tick), .tick(tick)
    );

    spi_bit_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .cke(cfg_cke), .smp(cfg_smp),
        .toggle(toggle), .launch(launch), .sample(sample), .finish(finish)
    );

    // Merge a sampled bit into the LSB, then shift left if a bit is driven.
    always_comb begin
        sr_smp = sample ? {sr_q[W-1:1], sdi} : sr_q;
        sr_nxt = launch ? {sr_smp[W-2:0], 1'b0} : sr_smp;
    end

    // Transfer datapath: buffer, shift register, serial clock and data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            sr_q   <= '0;
            sdo_q  <= 1'b0;
            sck_q  <= cfg_cpol;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (toggle) sck_q <= ~sck_q;
            sr_q <= sr_nxt;
            if (launch) sdo_q <= sr_smp[W-1];
            if (finish) begin
                buf_q  <= sr_smp;
                busy_q <= 1'b0;
            end
        end else begin
            sck_q <= cfg_cpol;
            if (wr_en) begin
                busy_q <= 1'b1;
                buf_q  <= wr_data;
                if (!cfg_cke) begin
                    sdo_q <= wr_data[W-1];
                    sr_q  <= {wr_data[W-2:0], 1'b0};
                end else begin
                    sr_q  <= wr_data;
                end
            end
        end
    end

    // Sticky status flags; a set outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (busy_q && finish) done_q <= 1'b1;
            else if (done_clr)    done_q <= 1'b0;
            if (busy_q && wr_en)  wcol_q <= 1'b1;
            else if (wcol_clr)    wcol_q <= 1'b0;
        end
    end

    assign rd_data = buf_q;
    assign done    = done_q;
    assign wcol    = wcol_q;
    assign busy    = busy_q;
    assign sck     = sck_q;
    assign sdo     = sdo_q;

    // R3 and R10: the closing tick raises done and drops busy.
    a_r3_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && finish) |=> (done_q && !busy_q));
    // R6: after 16 toggles sck is back at the idle level.
    a_r6_sck_home: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && finish) |=> (sck_q == $past(cfg_cpol)));
    // R9: a write during a transfer flags a collision.
    a_r9_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_en) |=> wcol_q);
    // R9: a refused write leaves the buffer alone.
    a_r9_buf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && wr_en && !finish) |=> $stable(buf_q));
    // R1: a write while idle starts a transfer.
    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && wr_en) |=> busy_q);
endmodule

// File: tb/sim_spi_buf_master.sv
module sim_spi_buf_master;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_clk_sel = 2'd0;
    logic       cfg_cpol = 1'b1, cfg_cke = 1'b0, cfg_smp = 1'b0;
    logic       tmr_tick = 1'b0, wr_en = 1'b0, done_clr = 1'b0, wcol_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sdi = 1'b0;
    logic [7:0] rd_data;
    logic       done, wcol, busy, sck, sdo;

    int errs = 0, checks = 0;
    bit finished = 1'b0;
    int sdi_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit tmr_en = 1'b0;
    int tmr_div = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_buf_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel), .cfg_cpol(cfg_cpol),
        .cfg_cke(cfg_cke), .cfg_smp(cfg_smp), .tmr_tick(tmr_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .done_clr(done_clr), .wcol_clr(wcol_clr),
        .done(done), .wcol(wcol), .busy(busy), .sck(sck), .sdo(sdo), .sdi(sdi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    bit m_ok = 1'b0, m_busy, m_sck, m_sdo, m_done, m_wcol, m_fin, m_wset, m_tk;
    int m_hc, m_n, m_half, m_end, m_l;
    logic [7:0] m_tx, m_rx, m_buf;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_sck = cfg_cpol; m_sdo = 0; m_done = 0; m_wcol = 0;
            m_buf = 0; m_hc = 0; m_n = 0;
        end else begin
            m_fin = 0; m_wset = 0;
            if (m_busy) begin
                if (wr_en) m_wset = 1;
                m_half = (cfg_clk_sel == 0) ? 2 : (cfg_clk_sel == 1) ? 8 : 32;
                if (cfg_clk_sel == 3) m_tk = tmr_tick;
                else begin
                    m_tk = (m_hc == m_half - 1);
                    m_hc = m_tk ? 0 : m_hc + 1;
                end
                if (m_tk) begin
                    m_n++;
                    if (m_n <= 16) m_sck = !m_sck;
                    m_l = int'(cfg_cke);
                    for (int i = 0; i < 8; i++) begin
                        if (m_n == m_l + 2*i + 1 + int'(cfg_smp)) m_rx[7-i] = sdi;
                        if (m_n == m_l + 2*i) m_sdo = m_tx[7-i];
                    end
                    m_end = (cfg_cke && cfg_smp) ? 17 : 16;
                    if (m_n == m_end) begin m_fin = 1; m_buf = m_rx; m_busy = 0; end
                end
            end else begin
                m_sck = cfg_cpol;
                if (wr_en) begin
                    m_busy = 1; m_buf = wr_data; m_tx = wr_data; m_rx = 0;
                    m_n = 0; m_hc = 0;
                    if (!cfg_cke) m_sdo = wr_data[7];
                end
            end
            m_done = m_fin ? 1'b1 : (done_clr ? 1'b0 : m_done);
            m_wcol = m_wset ? 1'b1 : (wcol_clr ? 1'b0 : m_wcol);
        end
        m_ok = 1'b1;
    end

    // Compare every output with the model between edges; then move sdi and timer.
    always @(negedge clk) begin
        if (m_ok && !finished) begin
            chk("R6 sck", int'(sck), int'(m_sck));
            chk("R7 sdo", int'(sdo), int'(m_sdo));
            chk("R10 busy", int'(busy), int'(m_busy));
            chk("R3 done", int'(done), int'(m_done));
            chk("R9 wcol", int'(wcol), int'(m_wcol));
            chk("R2 R8 rd_data", int'(rd_data), int'(m_buf));
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi = (sdi_mode == 1) ? 1'b0 : (sdi_mode == 2) ? 1'b1 : lfsr[0];
        tmr_div = (tmr_div + 1) % 3;
        tmr_tick = tmr_en && (tmr_div == 0);
    end

    task automatic xfer(input logic [7:0] b, input logic [1:0] sel, input bit pol,
                        input bit cke, input bit smp, input bit collide);
        int n;
        int exp_len;
        @(negedge clk);
        cfg_clk_sel = sel; cfg_cpol = pol; cfg_cke = cke; cfg_smp = smp;
        @(negedge clk);
        chk("R6 idle sck", int'(sck), int'(pol));
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
        chk("R1 busy after write", int'(busy), 1);
        chk("R1 buffer shows byte", int'(rd_data), int'(b));
        n = 1;
        if (collide) begin
            repeat (4) begin @(negedge clk); n++; end
            wr_en = 1; wr_data = ~b;
            @(negedge clk); n++;
            wr_en = 0;
            chk("R9 wcol set", int'(wcol), 1);
            chk("R9 buffer kept", int'(rd_data), int'(b));
        end
        while (busy) begin @(negedge clk); if (busy) n++; end
        if (sel != 2'd3) begin
            exp_len = ((cke && smp) ? 17 : 16) * ((sel == 0) ? 2 : (sel == 1) ? 8 : 32);
            chk("R4 R10 busy length", n, exp_len);
        end
        chk("R3 done set", int'(done), 1);
        chk("R6 sck home", int'(sck), int'(pol));
        repeat (2) @(negedge clk);
        chk("R3 done sticky", int'(done), 1);
        chk("R11 sdo held idle", int'(sdo), int'(m_sdo));
        done_clr = 1; wcol_clr = 1;
        @(negedge clk);
        done_clr = 0; wcol_clr = 0;
        chk("R3 done cleared", int'(done), 0);
        chk("R9 wcol cleared", int'(wcol), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset sck", int'(sck), 1);
        chk("R11 reset sdo", int'(sdo), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset flags", int'({done, wcol}), 0);
        chk("R11 reset buffer", int'(rd_data), 0);
        rst_n = 1;
        // R7 R8: all four launch/sample combinations, both polarities, random sdi.
        xfer(8'hA5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        xfer(8'h3C, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        xfer(8'h96, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        xfer(8'h5B, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R4: slower dividers.
        xfer(8'hC3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        xfer(8'h71, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: timer-driven ticks.
        tmr_en = 1;
        xfer(8'hE8, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        tmr_en = 0;
        // R2: constant sdi gives an all-ones and an all-zeros byte.
        sdi_mode = 2;
        xfer(8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 all ones received", int'(rd_data), 8'hFF);
        sdi_mode = 1;
        xfer(8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 all zeros received", int'(rd_data), 8'h00);
        sdi_mode = 0;
        // R9: collision during a transfer.
        xfer(8'h4E, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R5: with no timer pulses the transfer stalls.
        cfg_clk_sel = 2'd3;
        @(negedge clk); wr_en = 1; wr_data = 8'h11;
        @(negedge clk); wr_en = 0;
        repeat (20) @(negedge clk);
        chk("R5 stalled without pulses", int'({busy, sck}), 2);
        tmr_en = 1;
        while (busy) @(negedge clk);
        tmr_en = 0;
        chk("R5 finishes with pulses", int'(done), 1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule